// File: doc/BRIEF.md
# Integer ALU with Compare and Shift

This is a purely combinational integer arithmetic and logic unit of parameterizable width (64 bits by default). It sits in the execute stage of a simple load/store processor pipeline. It takes two operands, a 4-bit operation code and a shift amount. In the same cycle it returns a result word, a flag that is set when the result is all zeros, and a signed-overflow flag. A trap unit outside the block is expected to use that flag to raise an exception.

Addition and subtraction share one adder. The signed and unsigned variants produce the same result word and differ only in whether overflow is reported. The signed compare reuses the subtractor: it takes the sign of A−B and corrects it with the overflow of that subtraction, then places the answer in bit 0 of an otherwise cleared result. There is no inversion opcode. Bitwise NOT is done with NOR, against zero or against the operand itself. Shifts and the upper-immediate load act on operand B. The block holds no state, so there are no states or transitions to name.

Top module: `alu_core`

## Requirements
- R1: Code 0 (signed add) and code 1 (unsigned add) give result = A + B modulo 2^W.
- R2: Code 2 (signed subtract) and code 3 (unsigned subtract) give result = A − B modulo 2^W.
- R3: The overflow flag is 1 only for codes 0 and 2. It is set when the carry into the top bit differs from the carry out of it, which means the true signed result does not fit in W bits. Codes 1 and 3 and every other code always give 0, even when the result wraps.
- R4: Code 4 gives the bitwise AND of A and B, and code 5 gives the bitwise OR.
- R5: Code 6 gives the bitwise NOR of A and B. With B = 0, or with B = A, this yields the inverse of A.
- R6: Code 7 gives a result with bit 0 = 1 when A < B as signed two's-complement numbers, and 0 otherwise. All other bits are 0. The compare is correct even when A − B overflows.
- R7: Code 8 shifts B left by the shift amount and fills the vacated low bits with 0.
- R8: Code 9 shifts B right logically and fills with 0. Code 10 shifts B right arithmetically and fills with copies of B's top bit.
- R9: Only the low log2(W) bits of the shift input set the shift distance. Higher bits have no effect.
- R10: Code 11 places B[15:0] in result bits 31:16 and clears bits 15:0. For W > 32, bits above 31 copy bit 31.
- R11: The zero flag is 1 exactly when every result bit is 0, for every operation code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand; also the source for shifts and the upper-immediate load |
| op_sel | input | 4 | Operation code (0–11) |
| shamt | input | SHAMT_IN_W | Shift amount; only the low log2(W) bits are used |
| result | output | W | Operation result |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow of add/subtract |

## Verification
The adder paths are driven with pairs chosen at the signed limits. These pairs separate true signed overflow from a plain unsigned wrap and from sums that only come close to the boundary. The compare is run on operand pairs whose difference overflows, where a bare sign test would give the wrong answer. The shifter gets distances of 0, 1, W−1 and values with the upper select bits set. Together these separate zero fill from sign fill and catch masking errors. Random operands for every code are then checked against a behavioural model in the bench.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_NOR  = 4'd6,
        OP_SLT  = 4'd7,
        OP_SLL  = 4'd8,
        OP_SRL  = 4'd9,
        OP_SRA  = 4'd10,
        OP_LUI  = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_NOR = 2'd2
    } bw_sel_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf_raw,
    output logic         less
);
    logic [W-1:0] b_eff;
    logic [W-1:0] low;
    logic         c_into_top;
    logic         c_out_top;
    logic         top_bit;

    always_comb begin
        b_eff      = sub ? ~b : b;
        low        = {1'b0, a[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, sub};
        c_into_top = low[W-1];
        top_bit    = a[W-1] ^ b_eff[W-1] ^ c_into_top;
        c_out_top  = (a[W-1] & b_eff[W-1]) | (c_into_top & (a[W-1] ^ b_eff[W-1]));
        sum        = {top_bit, low[W-2:0]};
        ovf_raw    = c_into_top ^ c_out_top;
        less       = top_bit ^ ovf_raw;
    end

    always_comb begin
        // R3: carry-based overflow agrees with the operand/result sign rule
        p_ovf_sign_r3: assert (ovf_raw == ((a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1])))
            else $error("overflow flag disagrees with sign rule");
    end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  bw_sel_e      sel,
    output logic [W-1:0] out
);
    always_comb begin
        unique case (sel)
            BW_AND:  out = a & b;
            BW_OR:   out = a | b;
            BW_NOR:  out = ~(a | b);
            default: out = '0;
        endcase
    end

    always_comb begin
        // R5: NOR output never shares a set bit with either operand
        if (sel == BW_NOR)
            p_nor_disjoint_r5: assert ((out & (a | b)) == '0)
                else $error("NOR output overlaps operand bits");
    end

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int W  = 64,
    parameter int SW = 6
) (
    input  logic [W-1:0]  val,
    input  logic [SW-1:0] amt,
    input  logic          dir_right,
    input  logic          arith,
    output logic [W-1:0]  out
);
    logic [W-1:0] val_rev;
    logic [W-1:0] stage [SW+1];
    logic [W-1:0] res_rev;
    logic         fill;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign val_rev[i] = val[W-1-i];
        assign res_rev[i] = stage[SW][W-1-i];
    end

    assign fill     = arith & dir_right & val[W-1];
    assign stage[0] = dir_right ? val : val_rev;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int D = 1 << k;
        assign stage[k+1] = amt[k] ? {{D{fill}}, stage[k][W-1:D]} : stage[k];
    end

    assign out = dir_right ? stage[SW] : res_rev;

    always_comb begin
        // R8: arithmetic right shift keeps the sign bit
        if (dir_right && arith)
            p_sra_sign_r8: assert (out[W-1] == val[W-1])
                else $error("arithmetic shift lost sign");
        // R7: a nonzero left shift clears bit 0
        if (!dir_right && amt != '0)
            p_sll_fill_r7: assert (out[0] == 1'b0)
                else $error("left shift did not zero-fill");
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int W          = 64,
    parameter int SHAMT_IN_W = 8
) (
    input  logic [W-1:0]          opnd_a,
    input  logic [W-1:0]          opnd_b,
    input  logic [3:0]            op_sel,
    input  logic [SHAMT_IN_W-1:0] shamt,
    output logic [W-1:0]          result,
    output logic                  zero,
    output logic                  ovf
);
    localparam int SW = $clog2(W);

    alu_op_e      op;
    logic         do_sub;
    logic [W-1:0] as_sum;
    logic         as_ovf;
    logic         as_less;
    bw_sel_e      bw_sel;
    logic [W-1:0] bw_out;
    logic         sh_right;
    logic         sh_arith;
    logic [W-1:0] sh_out;
    logic [W-1:0] lui_val;
    logic         shamt_hi_unused;

    assign op              = alu_op_e'(op_sel);
    assign do_sub          = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT);
    assign sh_right        = (op == OP_SRL) || (op == OP_SRA);
    assign sh_arith        = (op == OP_SRA);
    assign shamt_hi_unused = ^shamt[SHAMT_IN_W-1:SW];

    always_comb begin
        unique case (op)
            OP_OR:   bw_sel = BW_OR;
            OP_NOR:  bw_sel = BW_NOR;
            default: bw_sel = BW_AND;
        endcase
    end

    alu_addsub #(.W(W)) u_addsub (
        .a(opnd_a), .b(opnd_b), .sub(do_sub),
        .sum(as_sum), .ovf_raw(as_ovf), .less(as_less)
    );

    alu_bitwise #(.W(W)) u_bitwise (
        .a(opnd_a), .b(opnd_b), .sel(bw_sel), .out(bw_out)
    );

    alu_shift #(.W(W), .SW(SW)) u_shift (
        .val(opnd_b), .amt(shamt[SW-1:0]), .dir_right(sh_right),
        .arith(sh_arith), .out(sh_out)
    );

    if (W > 32) begin : g_lui_wide
        assign lui_val = {{(W-32){opnd_b[15]}}, opnd_b[15:0], 16'h0000};
    end else begin : g_lui_narrow
        assign lui_val = {opnd_b[15:0], 16'h0000};
    end

    always_comb begin
        ovf = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                result = as_sum;
                ovf    = as_ovf;
            end
            OP_ADDU, OP_SUBU:      result = as_sum;
            OP_AND, OP_OR, OP_NOR: result = bw_out;
            OP_SLT:                result = {{(W-1){1'b0}}, as_less};
            OP_SLL, OP_SRL, OP_SRA: result = sh_out;
            OP_LUI:                result = lui_val;
            default:               result = '0;
        endcase
        zero = (result == '0);
    end

    always_comb begin
        // R6: compare bit matches a signed comparison of the operands
        if (op == OP_SLT)
            p_slt_signed_r6: assert (result == (($signed(opnd_a) < $signed(opnd_b)) ? W'(1) : W'(0)))
                else $error("set-less-than mismatch");
        // R3: unsigned and non-arithmetic codes never report overflow
        if (op != OP_ADD && op != OP_SUB)
            p_no_overflow_r3: assert (!ovf)
                else $error("overflow on non-signed op");
        // R10: upper-immediate load clears the low half-word
        if (op == OP_LUI)
            p_lui_low_r10: assert (result[15:0] == 16'h0000)
                else $error("upper-immediate low bits set");
    end

endmodule

// File: tb/alu_core_test.sv
module alu_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 64;
    localparam int SI = 8;

    logic          clk = 1'b0;
    logic [W-1:0]  opnd_a = '0;
    logic [W-1:0]  opnd_b = '0;
    logic [3:0]    op_sel = 4'd0;
    logic [SI-1:0] shamt = '0;
    logic [W-1:0]  result;
    logic          zero;
    logic          ovf;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_core #(.W(W), .SHAMT_IN_W(SI)) uut (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .shamt(shamt),
        .result(result), .zero(zero), .ovf(ovf)
    );

    task automatic model(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [SI-1:0] sh, output logic [W-1:0] r, output logic v);
        int d = int'(sh[5:0]);
        v = 1'b0;
        case (op)
            4'd0: begin r = a + b; v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]); end
            4'd1: r = a + b;
            4'd2: begin r = a - b; v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]); end
            4'd3: r = a - b;
            4'd4: r = a & b;
            4'd5: r = a | b;
            4'd6: r = ~(a | b);
            4'd7: r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
            4'd8: r = b << d;
            4'd9: r = b >> d;
            4'd10: r = $unsigned($signed(b) >>> d);
            4'd11: r = {{32{b[15]}}, b[15:0], 16'h0000};
            default: r = '0;
        endcase
    endtask

    task automatic chk(input string tag, input logic [3:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [SI-1:0] sh);
        logic [W-1:0] er;
        logic ev;
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; shamt = sh;
        #1;
        model(op, a, b, sh, er, ev);
        checks++;
        if (result !== er || zero !== (er == '0) || ovf !== ev) begin
            errors++;
            $display("FAIL %s op=%0d: result=%h zero=%b ovf=%b expected result=%h zero=%b ovf=%b",
                     tag, op, result, zero, ovf, er, (er == '0), ev);
        end
    endtask

    localparam logic [W-1:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [W-1:0] MINN = 64'h8000_0000_0000_0000;
    localparam logic [W-1:0] ONES = '1;

    task automatic t_idle_r11;
        chk("R11 idle zero", 4'd0, '0, '0, '0);
        chk("R11 sub equal", 4'd3, 64'h1234, 64'h1234, '0);
        chk("R11 unused code", 4'd15, ONES, ONES, '0);
    endtask

    task automatic t_add_r1;
        chk("R1 add small", 4'd0, 64'd5, 64'd7, '0);
        chk("R1 addu wrap", 4'd1, ONES, 64'd1, '0);
        chk("R1 add neg", 4'd0, ONES, ONES, '0);
    endtask

    task automatic t_sub_r2;
        chk("R2 sub", 4'd2, 64'd3, 64'd10, '0);
        chk("R2 subu wrap", 4'd3, 64'd0, 64'd1, '0);
    endtask

    task automatic t_overflow_r3;
        chk("R3 add ovf pos", 4'd0, MAXP, 64'd1, '0);
        chk("R3 add ovf neg", 4'd0, MINN, ONES, '0);
        chk("R3 add near", 4'd0, MAXP, 64'd0, '0);
        chk("R3 addu no flag", 4'd1, MAXP, 64'd1, '0);
        chk("R3 sub ovf", 4'd2, MINN, 64'd1, '0);
        chk("R3 sub ovf2", 4'd2, MAXP, ONES, '0);
        chk("R3 subu no flag", 4'd3, MINN, 64'd1, '0);
        chk("R3 slt no flag", 4'd7, MINN, 64'd1, '0);
    endtask

    task automatic t_logic_r4;
        chk("R4 and", 4'd4, 64'hF0F0_1234_0000_FFFF, 64'hFF00_FF00_FFFF_0F0F, '0);
        chk("R4 or", 4'd5, 64'hF0F0_1234_0000_FFFF, 64'h0F00_0001_8000_0000, '0);
    endtask

    task automatic t_nor_r5;
        chk("R5 nor", 4'd6, 64'hA5A5_0000_FFFF_1111, 64'h0F0F_0000_0000_2222, '0);
        chk("R5 not via zero", 4'd6, 64'hDEAD_BEEF_0123_4567, 64'd0, '0);
        chk("R5 not via self", 4'd6, 64'hDEAD_BEEF_0123_4567, 64'hDEAD_BEEF_0123_4567, '0);
    endtask

    task automatic t_slt_r6;
        chk("R6 slt neg<pos", 4'd7, ONES, 64'd1, '0);
        chk("R6 slt pos>neg", 4'd7, 64'd1, ONES, '0);
        chk("R6 slt equal", 4'd7, 64'd9, 64'd9, '0);
        chk("R6 slt ovf min<max", 4'd7, MINN, MAXP, '0);
        chk("R6 slt ovf max>min", 4'd7, MAXP, MINN, '0);
    endtask

    task automatic t_shift_r7_r8;
        chk("R7 sll 0", 4'd8, '0, 64'hFFFF_0000_1234_5679, 8'd0);
        chk("R7 sll 4", 4'd8, '0, 64'hFFFF_0000_1234_5679, 8'd4);
        chk("R7 sll 63", 4'd8, '0, 64'd3, 8'd63);
        chk("R8 srl 1", 4'd9, '0, MINN, 8'd1);
        chk("R8 srl 63", 4'd9, '0, ONES, 8'd63);
        chk("R8 sra 1", 4'd10, '0, MINN, 8'd1);
        chk("R8 sra 63", 4'd10, '0, MINN, 8'd63);
        chk("R8 sra pos", 4'd10, '0, MAXP, 8'd8);
    endtask

    task automatic t_shamt_r9;
        chk("R9 sll high bits", 4'd8, '0, 64'h1, 8'hC3);
        chk("R9 srl high bits", 4'd9, '0, ONES, 8'h41);
        chk("R9 sra high bits", 4'd10, '0, MINN, 8'h80);
    endtask

    task automatic t_lui_r10;
        chk("R10 lui pos", 4'd11, ONES, 64'hFFFF_FFFF_FFFF_1234, '0);
        chk("R10 lui neg", 4'd11, '0, 64'h0000_0000_0000_8001, '0);
        chk("R10 lui zero", 4'd11, ONES, 64'hFFFF_FFFF_FFFF_0000, '0);
    endtask

    task automatic t_random;
        for (int i = 0; i < 600; i++) begin
            logic [W-1:0] a = {$urandom, $urandom};
            logic [W-1:0] b = {$urandom, $urandom};
            logic [3:0] op = 4'($urandom_range(0, 11));
            logic [SI-1:0] sh = SI'($urandom);
            if (i % 5 == 0) b = a;
            chk("R1 R2 R3 R6 R11 random", op, a, b, sh);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_idle_r11();
        t_add_r1();
        t_sub_r2();
        t_overflow_r3();
        t_logic_r4();
        t_nor_r5();
        t_slt_r6();
        t_shift_r7_r8();
        t_shamt_r9();
        t_lui_r10();
        t_random();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule